// File: doc/BRIEF.md
# Triple-Channel Prescaled Timer

This block holds three separate 16-bit timers that count upward. They share one input clock and sit behind a small register bus with 32-bit data. Each timer either runs freely and rolls over past its top value, or restarts from zero whenever it reaches a programmed limit. When it restarts it flags an interval event. A per-timer divider can slow the count to one step every 2^(N+1) input clocks. Each timer also has three compare registers. Each can flag an event when the count arrives at its value.

Events collect in a sticky status register per timer. Software acknowledges them by writing ones to the bits it wants to clear, so writing back a value just read clears everything that was pending. An enable mask picks which status bits drive that timer's level interrupt line. Counting stops while the disable bit in the counter control register is set. Writing a one to the restart bit of that register zeroes the count and the divider phase in a single write. The restart bit never reads back as set.

The bus is a plain register port with no back-pressure. A write takes effect at the clock edge on which `bus_wr` is high. A read returns data in the same cycle that `bus_rd` is high. There are no wait states and no ready signal, so the bus master may issue one access per cycle.

Top module: `tri_prescaled_timer`

## Requirements
- R1: After reset, every counter control register reads 0x21 (stopped, waveform-disable bit set), all other registers read 0 and all interrupt lines are low.
- R2: The byte address is decoded as word index = kind*3 + channel, with bits 1:0 ignored. Kind order: clock control 0, counter control 1, count 2, interval 3, compare 1..3 as 4..6, status 7, interrupt enable 8. So timer 0 sees its registers at 0x00, 0x0C, 0x18, 0x24, 0x30, 0x3C, 0x48, 0x54 and 0x60, and timer n adds 4*n. Word indices 27 and above read 0, and writes to them have no effect.
- R3: With counter control bit 1 clear, each tick raises the count by one, and 0xFFFF steps to 0 without setting any status bit.
- R4: While counter control bit 0 is 1, the count and the divider phase hold.
- R5: Writing counter control with bit 4 set zeroes the count and the divider phase at that edge and suppresses that cycle's events. Bit 4 reads back as 0.
- R6: With counter control bit 1 set, a tick taken while the count equals the interval register makes the count 0 and sets status bit 0.
- R7: Clock control bit 0 enables the divider, and bits 4:1 hold N. While enabled, a tick comes every 2^(N+1) clocks (0x9 gives 32). While disabled, every clock is a tick.
- R8: With counter control bit 3 set, a tick that brings the count to the value of compare register k (k = 1..3) sets status bit k.
- R9: Each interrupt line is high exactly while some status bit of that timer is set with its matching interrupt-enable bit, and it stays high until the status is cleared. With enable 0 the line stays low.
- R10: Writing the status register clears each bit whose data bit is 1. An event arriving in the same cycle still sets its bit.
- R11: Writes to the count register are ignored. Counter control keeps only bits 0, 1, 3 and 5, and the other bits read as 0. Bit 5 has no effect on counting.
- R12: Writes addressed to one timer leave the other two timers' registers and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| irq | output | 3 | Level interrupt, one per timer |

## Verification
The bench targets the edges of the count. These are the roll-over from 0xFFFF, which a design that saturated or flagged an event would get wrong, and the interval restart, which breaks if the compare happens one tick late or the status is set on the wrong step. It checks that the divider produces exactly one tick per 32 clocks at setting 0x9, since an off-by-one power of two would visibly change the count. It also tests write-back clearing of status, the self-clearing restart bit, the stride between interleaved timers, and writes that must change nothing. A decode that mixed up channel and kind would corrupt a neighbour's register in these cases. A status bit that cleared on read, or a restart bit that stuck at one, would also show up in the read data.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  // register kinds; the order sets the address map (word = kind*channels + channel)
  typedef enum int {
    K_CLK = 0,
    K_CTL = 1,
    K_CNT = 2,
    K_IVL = 3,
    K_MT1 = 4,
    K_MT2 = 5,
    K_MT3 = 6,
    K_STS = 7,
    K_IEN = 8
  } reg_kind_e;

  localparam int KINDS    = 9;
  localparam int N_MATCH  = 3;
  localparam int N_EVT    = N_MATCH + 1;
  localparam int CTL_W    = 6;

  // counter control bit positions
  localparam int CTL_OFF  = 0;
  localparam int CTL_IVL  = 1;
  localparam int CTL_MEN  = 3;
  localparam int CTL_RST  = 4;
  localparam int CTL_WAV  = 5;

  localparam logic [CTL_W-1:0] CTL_KEEP  = 6'b10_1011;
  localparam logic [CTL_W-1:0] CTL_INIT  = 6'h21;
endpackage

// File: rtl/tpt_prescaler.sv
module tpt_prescaler #(
  parameter int PW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          div_en,
  input  logic [NW-1:0] div_sel,
  input  logic          restart,
  output logic          tick
);
  localparam int SW = PW + 1;

  logic [PW-1:0] phase_q;
  logic [SW-1:0] span;
  logic [SW-1:0] last_w;
  logic          at_last;
  logic          unused_hi;

  assign span      = SW'(1) << (int'(div_sel) + 1);
  assign last_w    = span - SW'(1);
  assign unused_hi = last_w[PW];
  assign at_last   = (phase_q == last_w[PW-1:0]);
  assign tick      = run && (!div_en || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (!div_en || at_last) phase_q <= '0;
      else                    phase_q <= phase_q + PW'(1);
    end
  end
endmodule

// File: rtl/tpt_compare.sv
module tpt_compare #(
  parameter int CW = 16,
  parameter int NM = 3
) (
  input  logic [CW-1:0] value,
  input  logic [CW-1:0] ref_val [NM],
  input  logic          enable,
  output logic [NM-1:0] hit
);
  for (genvar j = 0; j < NM; j++) begin : g_cmp
    assign hit[j] = enable && (value == ref_val[j]);
  end
endmodule

// File: rtl/tpt_channel.sv
module tpt_channel
  import tpt_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int NW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [KINDS-1:0]    wstb,
  input  logic [31:0]         wdata,
  output logic [NW:0]         cfg_o,
  output logic [CTL_W-1:0]    ctl_o,
  output logic [CW-1:0]       count_o,
  output logic [CW-1:0]       ivl_o,
  output logic [CW-1:0]       match_o [N_MATCH],
  output logic [N_EVT-1:0]    sts_o,
  output logic [N_EVT-1:0]    ien_o,
  output logic                irq_o
);
  logic [NW:0]          cfg_q;
  logic [CTL_W-1:0]     ctl_q;
  logic [CW-1:0]        count_q, ivl_q, cnt_nx;
  logic [CW-1:0]        match_q [N_MATCH];
  logic [N_EVT-1:0]     sts_q, ien_q, evt, set_v;
  logic [N_MATCH-1:0]   hit;
  logic                 tick, restart, at_ivl, unused_bits;

  assign unused_bits = ^{wdata, wstb[K_CNT]};
  assign restart     = wstb[K_CTL] && wdata[CTL_RST];
  assign at_ivl      = ctl_q[CTL_IVL] && (count_q == ivl_q);
  assign cnt_nx      = at_ivl ? '0 : count_q + CW'(1);

  tpt_prescaler #(.PW(PW), .NW(NW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!ctl_q[CTL_OFF]),
    .div_en  (cfg_q[0]),
    .div_sel (cfg_q[NW:1]),
    .restart (restart),
    .tick    (tick)
  );

  tpt_compare #(.CW(CW), .NM(N_MATCH)) u_cmp (
    .value   (cnt_nx),
    .ref_val (match_q),
    .enable  (ctl_q[CTL_MEN]),
    .hit     (hit)
  );

  assign evt   = tick ? {hit, at_ivl} : '0;
  assign set_v = restart ? '0 : evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (restart) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ctl_q <= CTL_INIT;
      ivl_q <= '0;
      ien_q <= '0;
    end else begin
      if (wstb[K_CLK]) cfg_q <= wdata[NW:0];
      if (wstb[K_CTL]) ctl_q <= wdata[CTL_W-1:0] & CTL_KEEP;
      if (wstb[K_IVL]) ivl_q <= wdata[CW-1:0];
      if (wstb[K_IEN]) ien_q <= wdata[N_EVT-1:0];
    end
  end

  for (genvar j = 0; j < N_MATCH; j++) begin : g_mreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 match_q[j] <= '0;
      else if (wstb[K_MT1 + j])   match_q[j] <= wdata[CW-1:0];
    end
    assign match_o[j] = match_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      sts_q <= (wstb[K_STS] ? (sts_q & ~wdata[N_EVT-1:0]) : sts_q) | set_v;
    end
  end

  assign cfg_o   = cfg_q;
  assign ctl_o   = ctl_q;
  assign count_o = count_q;
  assign ivl_o   = ivl_q;
  assign sts_o   = sts_q;
  assign ien_o   = ien_q;
  assign irq_o   = |(sts_q & ien_q);
endmodule

// File: rtl/tpt_decode.sv
module tpt_decode
  import tpt_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 8
) (
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      rd_word [NCH][KINDS],
  output logic [KINDS-1:0] wstb [NCH],
  output logic [31:0]      rdata
);
  localparam int SLOTS = NCH * KINDS;

  int  widx, kind, chn;
  logic hit;

  always_comb begin
    widx = int'(bus_addr[AW-1:2]);
    kind = widx / NCH;
    chn  = widx % NCH;
    hit  = (widx < SLOTS);
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < KINDS; k++) begin
        wstb[c][k] = bus_wr && hit && (kind == k) && (chn == c) && (k != int'(K_CNT));
        if (bus_rd && hit && (kind == k) && (chn == c)) rdata = rd_word[c][k];
      end
    end
  end
endmodule

// File: rtl/tri_prescaled_timer.sv
module tri_prescaled_timer
  import tpt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int AW     = 8,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [KINDS-1:0] wstb [NUM_CH];
  logic [31:0]      rd_word [NUM_CH][KINDS];

  logic [SEL_W:0]     ch_cfg   [NUM_CH];
  logic [CTL_W-1:0]   ch_ctl   [NUM_CH];
  logic [CNT_W-1:0]   ch_count [NUM_CH];
  logic [CNT_W-1:0]   ch_ivl   [NUM_CH];
  logic [CNT_W-1:0]   ch_match [NUM_CH][N_MATCH];
  logic [N_EVT-1:0]   ch_sts   [NUM_CH];
  logic [N_EVT-1:0]   ch_ien   [NUM_CH];

  tpt_decode #(.NCH(NUM_CH), .AW(AW)) u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .rd_word  (rd_word),
    .wstb     (wstb),
    .rdata    (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tpt_channel #(.CW(CNT_W), .PW(DIV_W), .NW(SEL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wstb    (wstb[c]),
      .wdata   (bus_wdata),
      .cfg_o   (ch_cfg[c]),
      .ctl_o   (ch_ctl[c]),
      .count_o (ch_count[c]),
      .ivl_o   (ch_ivl[c]),
      .match_o (ch_match[c]),
      .sts_o   (ch_sts[c]),
      .ien_o   (ch_ien[c]),
      .irq_o   (irq[c])
    );

    assign rd_word[c][K_CLK] = 32'(ch_cfg[c]);
    assign rd_word[c][K_CTL] = 32'(ch_ctl[c]);
    assign rd_word[c][K_CNT] = 32'(ch_count[c]);
    assign rd_word[c][K_IVL] = 32'(ch_ivl[c]);
    for (genvar j = 0; j < N_MATCH; j++) begin : g_mr
      assign rd_word[c][K_MT1 + j] = 32'(ch_match[c][j]);
    end
    assign rd_word[c][K_STS] = 32'(ch_sts[c]);
    assign rd_word[c][K_IEN] = 32'(ch_ien[c]);
  end
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
  parameter int NCH = 3,
  parameter int AW  = 8,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [NCH-1:0] irq,
  input logic [CW-1:0]  cnt0,
  input logic [5:0]     ctl0,
  input logic [3:0]     sts0,
  input logic [3:0]     ien0
);
  logic wr_ctl0, wr_sts0;
  assign wr_ctl0 = bus_wr && (int'(bus_addr[AW-1:2]) == 1 * NCH);
  assign wr_sts0 = bus_wr && (int'(bus_addr[AW-1:2]) == 7 * NCH);

  // restart bit zeroes the count at the write edge
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl0 && bus_wdata[4]) |=> (cnt0 == '0));

  // stopped timer does not move unless counter control is written
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0[0] && !wr_ctl0) |=> $stable(cnt0));

  // count only steps by one or returns to zero
  p_step_or_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt0) |-> ((cnt0 == $past(cnt0) + CW'(1)) || (cnt0 == '0)));

  // no enabled source, no interrupt
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien0 == '0) |-> !irq[0]);

  // status bits fall only after a status write
  p_sticky_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts0) & ~sts0)) |-> $past(wr_sts0));
endmodule

bind tri_prescaled_timer tpt_checker #(.NCH(NUM_CH), .AW(AW), .CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .cnt0      (ch_count[0]),
  .ctl0      (ch_ctl[0]),
  .sts0      (ch_sts[0]),
  .ien0      (ch_ien[0])
);

// File: tb/sim_tri_prescaled_timer.sv
module sim_tri_prescaled_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tri_prescaled_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_cfg [3], m_ctl [3], m_cnt [3], m_ivl [3], m_sts [3], m_ien [3], m_ph [3];
  int m_mt  [3][3];

  function automatic int model_read(int a);
    int w, k, c;
    w = a >> 2;
    if (w >= 27) return 0;
    k = w / 3; c = w % 3;
    case (k)
      0: return m_cfg[c];
      1: return m_ctl[c];
      2: return m_cnt[c];
      3: return m_ivl[c];
      4, 5, 6: return m_mt[c][k-4];
      7: return m_sts[c];
      default: return m_ien[c];
    endcase
  endfunction

  always @(posedge clk) begin
    int w, k, ch, lim, nph, ncnt, nsts, setv;
    bit hitw, tick, mine;
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_cfg[c] = 0; m_ctl[c] = 'h21; m_cnt[c] = 0; m_ivl[c] = 0;
        m_sts[c] = 0; m_ien[c] = 0; m_ph[c] = 0;
        for (int j = 0; j < 3; j++) m_mt[c][j] = 0;
      end
    end else begin
      w = int'(bus_addr) >> 2;
      hitw = bus_wr && (w < 27);
      k = w / 3; ch = w % 3;
      for (int c = 0; c < 3; c++) begin
        tick = 0; nph = m_ph[c]; ncnt = m_cnt[c]; setv = 0;
        if ((m_ctl[c] & 1) == 0) begin
          if (m_cfg[c] & 1) begin
            lim = (1 << (((m_cfg[c] >> 1) & 15) + 1)) - 1;
            if (m_ph[c] == lim) begin tick = 1; nph = 0; end
            else nph = m_ph[c] + 1;
          end else begin
            tick = 1; nph = 0;
          end
        end
        if (tick) begin
          if (((m_ctl[c] >> 1) & 1) && m_cnt[c] == m_ivl[c]) begin
            ncnt = 0; setv |= 1;
          end else ncnt = (m_cnt[c] + 1) & 'hFFFF;
          if ((m_ctl[c] >> 3) & 1)
            for (int j = 0; j < 3; j++) if (ncnt == m_mt[c][j]) setv |= (2 << j);
        end
        mine = hitw && (ch == c);
        if (mine && k == 1 && bus_wdata[4]) begin ncnt = 0; nph = 0; setv = 0; end
        nsts = m_sts[c];
        if (mine && k == 7) nsts &= ~int'(bus_wdata[3:0]);
        nsts |= setv;
        if (mine) begin
          case (k)
            0: m_cfg[c] = int'(bus_wdata[4:0]);
            1: m_ctl[c] = int'(bus_wdata[5:0]) & 'h2B;
            3: m_ivl[c] = int'(bus_wdata[15:0]);
            4, 5, 6: m_mt[c][k-4] = int'(bus_wdata[15:0]);
            8: m_ien[c] = int'(bus_wdata[3:0]);
            default: ;
          endcase
        end
        m_cnt[c] = ncnt; m_ph[c] = nph; m_sts[c] = nsts;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R9: interrupt lines compared with the reference every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 3; c++)
        check("R9 irq", int'(irq[c]), ((m_sts[c] & m_ien[c]) != 0) ? 1 : 0);
    end
  end

  task automatic bus_write(int a, int d);
    bus_addr = 8'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, string tag);
    bus_addr = 8'(a); bus_rd = 1'b1;
    #1;
    check(tag, int'(bus_rdata), model_read(a));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state of every register, R2: unmapped reads
    for (int a = 0; a < 27 * 4; a += 4) bus_read(a, "R1 reset value");
    check("R1 irq low", int'(irq), 0);
    bus_read('h6C, "R2 unmapped");
    bus_read('hFC, "R2 unmapped");

    // R2 / R12: interleaved stride, neighbours untouched
    bus_write('h28, 'h1234);
    bus_read('h28, "R2 stride ch1 interval");
    bus_read('h24, "R12 ch0 interval untouched");
    bus_read('h2C, "R12 ch2 interval untouched");
    bus_write('h6C, 'hFFFF);
    bus_read('h6C, "R2 unmapped write");

    // R3: free run on timer 0
    bus_write('h0C, 'h00);
    idle(10);
    bus_read('h18, "R3 free count");
    // R11: count register is read-only, control keeps only some bits
    bus_write('h18, 'h5555);
    bus_read('h18, "R11 count write ignored");
    bus_write('h14, 'h25);
    bus_read('h14, "R11 control bits kept");

    // R5: restart bit self-clears and zeroes count
    bus_write('h0C, 'h10);
    bus_read('h0C, "R5 restart bit reads 0");
    bus_read('h18, "R5 count after restart");

    // R4: stop holds the count
    bus_write('h0C, 'h01);
    bus_read('h18, "R4 stopped count");
    idle(6);
    bus_read('h18, "R4 still held");
    bus_read('h1C, "R12 ch1 idle count");

    // R7: divide by 32 on timer 1, then divide by 2
    bus_write('h04, 'h09);
    bus_write('h10, 'h10);
    idle(100);
    bus_read('h1C, "R7 divide 32");
    bus_write('h04, 'h01);
    bus_write('h10, 'h10);
    idle(9);
    bus_read('h1C, "R7 divide 2");

    // R6 / R9: interval mode with interrupt on timer 2
    bus_write('h2C, 5);
    bus_write('h68, 1);
    bus_write('h14, 'h12);
    idle(20);
    bus_read('h5C, "R6 interval status");
    bus_read('h20, "R6 count below interval");
    check("R9 irq ch2 raised", int'(irq[2]), 1);

    // R10: stop, then write back the read value
    bus_write('h14, 'h03);
    bus_read('h5C, "R10 status before clear");
    bus_write('h5C, model_read('h5C));
    bus_read('h5C, "R10 status cleared");
    check("R10 irq ch2 dropped", int'(irq[2]), 0);

    // R8: compare events on timer 0
    bus_write('h30, 7);
    bus_write('h48, 3);
    bus_write('h60, 'hE);
    bus_write('h0C, 'h18);
    idle(12);
    bus_read('h54, "R8 match status");
    bus_write('h60, 0);
    bus_read('h60, "R9 enable cleared");
    check("R9 irq masked", int'(irq[0]), 0);
    // R10: running clear while events continue
    bus_write('h54, 'hF);
    bus_read('h54, "R10 clear while running");

    // R3: roll-over on timer 1 without divider
    bus_write('h04, 'h00);
    bus_write('h10, 'h10);
    idle(65540);
    bus_read('h1C, "R3 wrapped count");
    bus_read('h58, "R3 no event on wrap");
    bus_read('h18, "R12 ch0 count");

    idle(2);
    finish_run();
  end
endmodule